// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner

This block scans a sixteen-key matrix arranged as four rows and four columns. It pulls one row line low at a time and holds the other rows high. It then reads the four column lines, which idle high. A column that reads low while a row is pulled low means the key where that row and that column cross is held down. The column lines are asynchronous to the block, so they pass through a multi-flop synchroniser first. After each row change the block waits a few cycles, which gives the synchronised columns time to show the new row.

A low column is not trusted at once. The block stays on the same row and column for a debounce interval, set in clock cycles, and then samples that column again. If the column is still low, the block issues the key index with a one-cycle strobe. The block then stays on that row until every column of the row reads high again. If the second sample finds the column high, the block drops the candidate and goes on to the next column of the same row. It does not restart the row.

The debounce length is a parameter. Silicon uses a value near ten milliseconds of clock cycles, and a test can use a short one.

Top module: `keypad_scan`

## Requirements
- R1: While reset is held and just after it is released, the row drive reads 4'b1110 (row 0 low, bit i drives row i) and the key strobe is low.
- R2: At every cycle out of reset, exactly one row line is driven low.
- R3: With no key held, the low row steps in the fixed order 1110, 1101, 1011, 0111 and then wraps back to 1110. It repeats this endlessly.
- R4: A confirmed key is issued as a code equal to row index times four plus column index: code[3:2] is the row and code[1:0] is the column. The key strobe is high for exactly one cycle per report.
- R5: A column low for fewer cycles than the debounce interval produces no report.
- R6: A key held for many scan periods is reported once. After every column of its row reads high again, scanning resumes, and a new press of the same key is reported again.
- R7: If the recheck after the debounce wait finds the column high, the block tests the next column of the same row. The row drive does not change in between.
- R8: Within a row, columns are tested from 0 upward. With two keys of one row held together, only the lower column is reported, and only once, until the whole row is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n_i | input | COLS (4) | Column sense lines, low when a key on the driven row is closed |
| row_n_o | output | ROWS (4) | Row drive, one line low at a time |
| key_code_o | output | CODE_W (4) | Index of the last confirmed key |
| key_valid_o | output | 1 | One-cycle strobe marking a new key code |

## Verification
The bench builds the scanner with a debounce interval of 20 cycles and the default two-stage synchroniser. A full scan then takes a few dozen cycles rather than half a million. This makes it practical to reach several cases within one run:
- a press that ends inside the debounce window;
- a candidate key that lets go between its first sample and its recheck while a neighbour on the same row stays closed;
- a key held across many scan periods.

It also checks the exact row rotation from reset.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

   typedef enum logic [2:0] {
      KS_SETTLE,
      KS_TEST,
      KS_WAIT,
      KS_CHECK,
      KS_HOLD
   } kpd_state_e;

   function automatic int kpd_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
   parameter int          W         = 4,
   parameter int          STAGES    = 2,
   parameter logic        RESET_LVL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("kpd_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("kpd_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= {(STAGES*W){RESET_LVL}};
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/kpd_timer.sv
module kpd_timer #(
   parameter int CNT_W     = 8,
   parameter int RESET_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("kpd_timer: CNT_W must be at least 1");
      end
      if (RESET_VAL >= (1 << CNT_W)) begin : g_bad_rst
         $error("kpd_timer: RESET_VAL does not fit in CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RESET_VAL);
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   // R5: the debounce window shrinks by one each cycle, never skips
   assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R5: an expired timer stays expired until reloaded
   assert_timer_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == '0) |=> expired_o);

endmodule

// File: rtl/kpd_row_drive.sv
module kpd_row_drive #(
   parameter int ROWS = 4,
   parameter int RW   = 2
) (
   input  logic [RW-1:0]   row_idx_i,
   output logic [ROWS-1:0] row_n_o
);

   generate
      for (genvar g = 0; g < ROWS; g++) begin : g_row
         assign row_n_o[g] = (row_idx_i != RW'(g));
      end
   endgenerate

endmodule

// File: rtl/kpd_scan_fsm.sv
module kpd_scan_fsm
   import kpd_pkg::*;
#(
   parameter int ROWS         = 4,
   parameter int COLS         = 4,
   parameter int DEBOUNCE_CYC = 500000,
   parameter int SETTLE_CYC   = 3,
   parameter int RW           = 2,
   parameter int CW           = 2,
   parameter int CODE_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COLS-1:0]   col_s_i,
   output logic [RW-1:0]     row_idx_o,
   output logic [CODE_W-1:0] key_code_o,
   output logic              key_valid_o
);

   localparam int                TMR_MAX  = kpd_max(DEBOUNCE_CYC, SETTLE_CYC);
   localparam int                TMR_W    = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0]  DEB_LD   = TMR_W'(DEBOUNCE_CYC - 1);
   localparam logic [TMR_W-1:0]  SET_LD   = TMR_W'(SETTLE_CYC - 1);
   localparam logic [RW-1:0]     LAST_ROW = RW'(ROWS - 1);
   localparam logic [CW-1:0]     LAST_COL = CW'(COLS - 1);
   localparam logic [CODE_W-1:0] COLS_C   = CODE_W'(COLS);

   generate
      if (DEBOUNCE_CYC < 1) begin : g_bad_deb
         $error("kpd_scan_fsm: DEBOUNCE_CYC must be at least 1");
      end
      if (SETTLE_CYC < 1) begin : g_bad_set
         $error("kpd_scan_fsm: SETTLE_CYC must be at least 1");
      end
   endgenerate

   kpd_state_e        state_q;
   logic [RW-1:0]     row_q;
   logic [CW-1:0]     col_q;
   logic [CODE_W-1:0] code_q;
   logic              valid_q;

   logic              col_hit;
   logic              last_col;
   logic              row_clear;
   logic              adv_row;
   logic              adv_col;
   logic              start_deb;
   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_done;

   assign col_hit   = ~col_s_i[col_q];
   assign last_col  = (col_q == LAST_COL);
   assign row_clear = &col_s_i;

   always_comb begin
      adv_row   = 1'b0;
      adv_col   = 1'b0;
      start_deb = 1'b0;
      unique case (state_q)
         KS_TEST: begin
            if (col_hit)       start_deb = 1'b1;
            else if (last_col) adv_row   = 1'b1;
            else               adv_col   = 1'b1;
         end
         KS_CHECK: begin
            if (!col_hit) begin
               if (last_col) adv_row = 1'b1;
               else          adv_col = 1'b1;
            end
         end
         KS_HOLD:   adv_row = row_clear;
         default: ;
      endcase
   end

   assign tmr_load = start_deb | adv_row;
   assign tmr_val  = start_deb ? DEB_LD : SET_LD;

   kpd_timer #(
      .CNT_W     (TMR_W),
      .RESET_VAL (SETTLE_CYC - 1)
   ) i_kpd_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KS_SETTLE;
         row_q   <= '0;
         col_q   <= '0;
         code_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (adv_row) begin
            row_q   <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
            col_q   <= '0;
            state_q <= KS_SETTLE;
         end else if (adv_col) begin
            col_q   <= col_q + 1'b1;
            state_q <= KS_TEST;
         end else begin
            unique case (state_q)
               KS_SETTLE: if (tmr_done) begin
                  col_q   <= '0;
                  state_q <= KS_TEST;
               end
               KS_TEST:   state_q <= KS_WAIT;
               KS_WAIT:   if (tmr_done) state_q <= KS_CHECK;
               KS_CHECK: begin
                  valid_q <= 1'b1;
                  code_q  <= CODE_W'(row_q) * COLS_C + CODE_W'(col_q);
                  state_q <= KS_HOLD;
               end
               KS_HOLD: ;
               default:   state_q <= KS_SETTLE;
            endcase
         end
      end
   end

   assign row_idx_o   = row_q;
   assign key_code_o  = code_q;
   assign key_valid_o = valid_q;

   // R4: the key strobe never lasts two cycles
   assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |=> !key_valid_o);

   // R7: row and column do not move while a candidate is being debounced
   assert_wait_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KS_WAIT) |=> ($stable(row_q) && $stable(col_q)));

   // R6: a held row keeps the scanner parked and silent
   assert_hold_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KS_HOLD && !row_clear) |=> (state_q == KS_HOLD && !key_valid_o));

   // R8: a strobe always follows a recheck of the selected column
   assert_strobe_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |-> ($past(state_q) == KS_CHECK));

endmodule

// File: rtl/keypad_scan.sv
module keypad_scan #(
   parameter int ROWS         = 4,
   parameter int COLS         = 4,
   parameter int DEBOUNCE_CYC = 500000,
   parameter int SYNC_STAGES  = 2,
   parameter int CODE_W       = $clog2(ROWS * COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COLS-1:0]   col_n_i,
   output logic [ROWS-1:0]   row_n_o,
   output logic [CODE_W-1:0] key_code_o,
   output logic              key_valid_o
);

   localparam int RW         = $clog2(ROWS);
   localparam int CW         = $clog2(COLS);
   localparam int SETTLE_CYC = SYNC_STAGES + 1;

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("keypad_scan: ROWS must be at least 2");
      end
      if (COLS < 2) begin : g_bad_cols
         $error("keypad_scan: COLS must be at least 2");
      end
      if (CODE_W < $clog2(ROWS * COLS)) begin : g_bad_code
         $error("keypad_scan: CODE_W too narrow for ROWS*COLS keys");
      end
   endgenerate

   logic [COLS-1:0] col_s;
   logic [RW-1:0]   row_idx;

   kpd_sync #(
      .W         (COLS),
      .STAGES    (SYNC_STAGES),
      .RESET_LVL (1'b1)
   ) i_kpd_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (col_n_i),
      .q_o   (col_s)
   );

   kpd_scan_fsm #(
      .ROWS         (ROWS),
      .COLS         (COLS),
      .DEBOUNCE_CYC (DEBOUNCE_CYC),
      .SETTLE_CYC   (SETTLE_CYC),
      .RW           (RW),
      .CW           (CW),
      .CODE_W       (CODE_W)
   ) i_kpd_scan_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .col_s_i     (col_s),
      .row_idx_o   (row_idx),
      .key_code_o  (key_code_o),
      .key_valid_o (key_valid_o)
   );

   kpd_row_drive #(
      .ROWS (ROWS),
      .RW   (RW)
   ) i_kpd_row_drive (
      .row_idx_i (row_idx),
      .row_n_o   (row_n_o)
   );

   logic [CODE_W-1:0] strobe_row;
   assign strobe_row = key_code_o / CODE_W'(COLS);

   // R2: one row line low at a time
   assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~row_n_o) == 1);

   // R3: any change of the row drive is a one-step rotation upward
   assert_row_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (row_n_o != $past(row_n_o)) |->
         (row_n_o == {$past(row_n_o[ROWS-2:0]), $past(row_n_o[ROWS-1])}));

   // R4: the reported row is the one being driven low
   assert_code_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |-> !row_n_o[strobe_row[RW-1:0]]);

endmodule

// File: tb/test_keypad_scan.sv
module test_keypad_scan;

   localparam int CLK_PERIOD = 10;
   localparam int DEB        = 20;
   localparam int WDOG_LIM   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] col_n;
   logic [3:0] row_n;
   logic [3:0] key_code;
   logic       key_valid;
   logic [15:0] keys = '0;

   int n_checks = 0;
   int n_fails  = 0;
   int n_valid  = 0;
   logic [3:0] exp_q[$];
   logic       prev_valid = 1'b0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // keypad model: a closed key pulls its column low while its row is driven low
   always_comb begin
      for (int c = 0; c < 4; c++) begin
         col_n[c] = 1'b1;
         for (int r = 0; r < 4; r++)
            if (keys[r*4+c] && !row_n[r]) col_n[c] = 1'b0;
      end
   end

   keypad_scan #(
      .DEBOUNCE_CYC (DEB)
   ) i_keypad_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .col_n_i     (col_n),
      .row_n_o     (row_n),
      .key_code_o  (key_code),
      .key_valid_o (key_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (key_valid) begin
            n_valid++;
            check(!prev_valid, "R4 strobe width", 2, 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5/R6 unexpected report", key_code, 16);
            end else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               check(key_code == e, "R4 key code", key_code, e);
            end
         end
         prev_valid <= key_valid;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tap(input int code, input int hold, input int gap);
      exp_q.push_back(4'(code));
      keys[code] = 1'b1;
      cyc(hold);
      keys[code] = 1'b0;
      cyc(gap);
   endtask

   initial begin : watchdog
      int k;
      for (k = 0; k < WDOG_LIM && !done; k++) @(posedge clk);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", k, WDOG_LIM);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int base;
      logic [3:0] last;
      bit stayed;
      bit seen;

      // R1: reset state
      cyc(3);
      check(row_n == 4'b1110, "R1 row drive in reset", row_n, 4'b1110);
      check(key_valid == 1'b0, "R1 strobe in reset", key_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(row_n == 4'b1110, "R1 row drive after reset", row_n, 4'b1110);
      check(key_valid == 1'b0, "R1 strobe after reset", key_valid, 0);

      // R2/R3: idle rotation
      last = row_n;
      for (int i = 0; i < 8; i++) begin
         int t;
         logic [3:0] want;
         want = {last[2:0], last[3]};
         t = 0;
         while (row_n == last && t < 100) begin
            @(negedge clk);
            t++;
         end
         check(row_n == want, "R3 row order", row_n, want);
         check($countones(~row_n) == 1, "R2 one row low", row_n, want);
         last = row_n;
      end

      // R4: several single presses across rows and columns
      tap(0,  150, 60);
      tap(5,  150, 60);
      tap(10, 150, 60);
      tap(15, 150, 60);
      tap(3,  150, 60);
      tap(12, 150, 60);
      check(n_valid == 6, "R4 report count", n_valid, 6);

      // R5: press shorter than the debounce window
      base = n_valid;
      keys[6] = 1'b1;
      cyc(8);
      keys[6] = 1'b0;
      cyc(200);
      check(n_valid == base, "R5 short press ignored", n_valid - base, 0);

      // R6: long hold reports once, re-press reports again
      base = n_valid;
      tap(9, 600, 80);
      check(n_valid == base + 1, "R6 long hold single report", n_valid - base, 1);
      tap(9, 150, 80);
      check(n_valid == base + 2, "R6 re-press reported", n_valid - base, 2);

      // R8: two keys in one row, lower column wins and only once
      base = n_valid;
      exp_q.push_back(4'd5);
      keys[5] = 1'b1;
      keys[7] = 1'b1;
      cyc(300);
      keys[5] = 1'b0;
      keys[7] = 1'b0;
      cyc(80);
      check(n_valid == base + 1, "R8 lower column only", n_valid - base, 1);

      // R7: candidate on column 1 lets go before recheck, column 2 held
      while (row_n == 4'b1110) @(negedge clk);
      while (row_n != 4'b1110) @(negedge clk);
      base = n_valid;
      exp_q.push_back(4'd2);
      keys[1] = 1'b1;
      keys[2] = 1'b1;
      cyc(10);
      keys[1] = 1'b0;
      stayed = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < 120 && !seen; i++) begin
         if (row_n != 4'b1110) stayed = 1'b0;
         if (key_valid) seen = 1'b1;
         @(negedge clk);
      end
      check(seen, "R7 next column reported", seen, 1);
      check(stayed, "R7 row held during recheck", stayed, 1);
      keys[2] = 1'b0;
      cyc(80);
      check(n_valid == base + 1, "R7 single report", n_valid - base, 1);

      check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule